// File: doc/BRIEF.md
# MMU Fault Capture Unit

This block sits beside a radix address translator. The translator hands it each failed translation as a fault event. The event carries the access kind (instruction fetch, data load or data store), the effective address and, when it exists, the guest real address. It also carries a cause vector and a fault class: segment, storage or hypervisor storage. On the same clock edge the unit picks an exception code and loads the status registers that the chosen code owns. That code is one of instruction segment, data segment, instruction storage, data storage, hypervisor instruction storage or hypervisor data storage. A one-cycle valid pulse then announces the result.

The unit also checks effective addresses and qualifies them, using combinational logic. The two most significant address bits pick a quadrant. With the hypervisor-state input it then selects which partition ID and which process ID apply. It flags the addresses that must become segment faults: those with a nonzero reserved field, and guest accesses to quadrants that guest state may not use. A fault event whose address fails this check is reported as a segment fault, whatever class the translator gave it.

Top module: `fault_capture_unit`

## Requirements
- R1: After reset, excValid is 0, excCode is 0 (none), and errCode, dsisr, dar, hdsisr, hdar and asdr are all zero.
- R2: Each cycle with faultValid high is followed by exactly one cycle with excValid high. excCode then holds the new code, encoded as 1 instruction segment, 2 data segment, 3 instruction storage, 4 data storage, 5 hypervisor instruction storage, 6 hypervisor data storage. excValid stays low after any cycle without faultValid.
- R3: The address check fails when bits [EA_W-3:EA_W-12] of effAddr (bits [61:52] at default width) are nonzero. A fault with a failing check, or with faultClass 0, is a segment fault. For a fetch (accessType 0) the code is instruction segment. For a load (1) or store (2) the code is data segment and dar takes effAddr. errCode is cleared in both cases, and no other status register changes.
- R4: With hvState 1, the quadrant effAddr[EA_W-1:EA_W-2] selects the IDs. Quadrant 0 gives partition 0 with pidReg. Quadrant 1 gives lpidReg with pidReg. Quadrant 2 gives lpidReg with process 0. Quadrant 3 gives partition 0 with process 0.
- R5: With hvState 0, quadrant 0 gives lpidReg with pidReg and quadrant 3 gives lpidReg with process 0. Quadrants 1 and 2 fail the address check, drive both IDs to zero, and turn any fault into a segment fault.
- R6: A storage fault (faultClass 1) on a fetch loads causeIn into errCode and leaves dsisr and dar unchanged.
- R7: A storage fault on a load or store writes dar with effAddr and clears errCode. It also writes dsisr with causeIn; for a store, bit STORE_BIT (25 by default) is also set in the dsisr value.
- R8: A hypervisor storage fault (faultClass 2 or 3) on a fetch writes asdr with guestRealAddr and errCode with causeIn. It leaves hdsisr and hdar unchanged.
- R9: A hypervisor storage fault on a load or store writes asdr with guestRealAddr and hdar with effAddr, and clears errCode. It writes hdsisr with causeIn, with bit STORE_BIT also set for a store.
- R10: In a cycle without faultValid, no status register and no error code changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultValid | input | 1 | Fault event present this cycle |
| accessType | input | 2 | 0 fetch, 1 load, 2 store, 3 treated as load |
| faultClass | input | 2 | 0 segment, 1 storage, 2 or 3 hypervisor storage |
| effAddr | input | EA_W | Effective address of the access |
| guestRealAddr | input | EA_W | Guest real address for hypervisor faults |
| causeIn | input | CAUSE_W | Cause vector from the translator |
| hvState | input | 1 | Processor is in hypervisor state |
| lpidReg | input | ID_W | Current partition ID register |
| pidReg | input | ID_W | Current process ID register |
| lpidSel | output | ID_W | Partition ID selected for effAddr |
| pidSel | output | ID_W | Process ID selected for effAddr |
| addrOk | output | 1 | effAddr passes the reserved-field and quadrant check |
| excValid | output | 1 | One-cycle pulse after a captured fault |
| excCode | output | 3 | Registered exception code |
| errCode | output | CAUSE_W | Error code of the last fault |
| dsisr | output | CAUSE_W | Data storage cause status |
| dar | output | EA_W | Data fault address |
| hdsisr | output | CAUSE_W | Hypervisor data storage cause status |
| hdar | output | EA_W | Hypervisor data fault address |
| asdr | output | EA_W | Guest real address of a hypervisor fault |

## Verification
Some rules are checked by the bound properties on every cycle. These are the pulse timing of excValid, the holding of all status registers when no fault arrives, and the address and error-code contents after data storage and hypervisor data storage faults. They also cover the untouched dsisr and dar after an instruction storage fault and the partition ID chosen in guest state. Other behaviour is shown only by the bench scenarios. This covers the OR-ing of the store bit into the cause and the full quadrant tables in both states. It also covers a bad address or an illegal guest quadrant overriding a storage class, and the cumulative register contents over back-to-back faults of different kinds.

// File: rtl/fcu_pkg.sv
package fcu_pkg;

  typedef enum logic [2:0] {
    EXC_NONE = 3'd0,
    EXC_ISEG = 3'd1,
    EXC_DSEG = 3'd2,
    EXC_ISI  = 3'd3,
    EXC_DSI  = 3'd4,
    EXC_HISI = 3'd5,
    EXC_HDSI = 3'd6
  } excCode_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_ALT   = 2'd3
  } access_e;

  // Write strobes sent from control to the datapath
  typedef struct packed {
    logic wrErr;
    logic errFromCause;
    logic addStore;
    logic wrDsisr;
    logic wrDar;
    logic wrHdsisr;
    logic wrHdar;
    logic wrAsdr;
  } strobe_t;

endpackage

// File: rtl/fcu_qualify.sv
module fcu_qualify #(
  parameter int EA_W = 64,
  parameter int ID_W = 32
) (
  input  logic [EA_W-1:0] effAddr,
  input  logic            hvState,
  input  logic [ID_W-1:0] lpidReg,
  input  logic [ID_W-1:0] pidReg,
  output logic [ID_W-1:0] lpidSel,
  output logic [ID_W-1:0] pidSel,
  output logic            addrOk
);
  localparam int QUAD_HI = EA_W - 1;
  localparam int RSV_HI  = EA_W - 3;
  localparam int RSV_W   = 10;

  logic [1:0] quadrant;
  logic       rsvBad;
  logic       quadLegal;

  assign quadrant = effAddr[QUAD_HI -: 2];
  assign rsvBad   = |effAddr[RSV_HI -: RSV_W];

  always_comb begin
    lpidSel   = '0;
    pidSel    = '0;
    quadLegal = 1'b1;
    if (hvState) begin
      unique case (quadrant)
        2'd0: pidSel = pidReg;
        2'd1: begin lpidSel = lpidReg; pidSel = pidReg; end
        2'd2: lpidSel = lpidReg;
        default: ;
      endcase
    end else begin
      unique case (quadrant)
        2'd0: begin lpidSel = lpidReg; pidSel = pidReg; end
        2'd3: lpidSel = lpidReg;
        default: quadLegal = 1'b0;
      endcase
    end
  end

  assign addrOk = quadLegal && !rsvBad;

endmodule

// File: rtl/fcu_ctrl.sv
module fcu_ctrl
  import fcu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       faultValid,
  input  logic [1:0] accessType,
  input  logic [1:0] faultClass,
  input  logic       addrOk,
  output strobe_t    strobes,
  output logic       excValid,
  output excCode_e   excCode
);
  logic     isFetch;
  logic     isStore;
  logic     isSegment;
  logic     isStorage;
  excCode_e nextCode;

  assign isFetch   = (accessType == ACC_FETCH);
  assign isStore   = (accessType == ACC_STORE);
  assign isSegment = !addrOk || (faultClass == 2'd0);
  assign isStorage = (faultClass == 2'd1);

  always_comb begin
    if (isSegment)      nextCode = isFetch ? EXC_ISEG : EXC_DSEG;
    else if (isStorage) nextCode = isFetch ? EXC_ISI  : EXC_DSI;
    else                nextCode = isFetch ? EXC_HISI : EXC_HDSI;
  end

  always_comb begin
    strobes              = '0;
    strobes.wrErr        = faultValid;
    strobes.errFromCause = (nextCode == EXC_ISI) || (nextCode == EXC_HISI);
    strobes.addStore     = isStore;
    strobes.wrDsisr      = faultValid && (nextCode == EXC_DSI);
    strobes.wrDar        = faultValid && ((nextCode == EXC_DSI) || (nextCode == EXC_DSEG));
    strobes.wrHdsisr     = faultValid && (nextCode == EXC_HDSI);
    strobes.wrHdar       = faultValid && (nextCode == EXC_HDSI);
    strobes.wrAsdr       = faultValid && ((nextCode == EXC_HDSI) || (nextCode == EXC_HISI));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excValid <= 1'b0;
      excCode  <= EXC_NONE;
    end else begin
      excValid <= faultValid;
      if (faultValid) excCode <= nextCode;
    end
  end

endmodule

// File: rtl/fcu_datapath.sv
module fcu_datapath
  import fcu_pkg::*;
#(
  parameter int EA_W      = 64,
  parameter int CAUSE_W   = 32,
  parameter int STORE_BIT = 25
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [EA_W-1:0]    effAddr,
  input  logic [EA_W-1:0]    guestRealAddr,
  input  logic [CAUSE_W-1:0] causeIn,
  output logic [CAUSE_W-1:0] errCode,
  output logic [CAUSE_W-1:0] dsisr,
  output logic [EA_W-1:0]    dar,
  output logic [CAUSE_W-1:0] hdsisr,
  output logic [EA_W-1:0]    hdar,
  output logic [EA_W-1:0]    asdr
);
  localparam logic [CAUSE_W-1:0] STORE_MASK = CAUSE_W'(1) << STORE_BIT;

  logic [CAUSE_W-1:0] statusCause;

  assign statusCause = strobes.addStore ? (causeIn | STORE_MASK) : causeIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errCode <= '0;
      dsisr   <= '0;
      dar     <= '0;
      hdsisr  <= '0;
      hdar    <= '0;
      asdr    <= '0;
    end else begin
      if (strobes.wrErr)    errCode <= strobes.errFromCause ? causeIn : '0;
      if (strobes.wrDsisr)  dsisr   <= statusCause;
      if (strobes.wrDar)    dar     <= effAddr;
      if (strobes.wrHdsisr) hdsisr  <= statusCause;
      if (strobes.wrHdar)   hdar    <= effAddr;
      if (strobes.wrAsdr)   asdr    <= guestRealAddr;
    end
  end

endmodule

// File: rtl/fault_capture_unit.sv
module fault_capture_unit
  import fcu_pkg::*;
#(
  parameter int EA_W      = 64,
  parameter int CAUSE_W   = 32,
  parameter int ID_W      = 32,
  parameter int STORE_BIT = 25
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               faultValid,
  input  logic [1:0]         accessType,
  input  logic [1:0]         faultClass,
  input  logic [EA_W-1:0]    effAddr,
  input  logic [EA_W-1:0]    guestRealAddr,
  input  logic [CAUSE_W-1:0] causeIn,
  input  logic               hvState,
  input  logic [ID_W-1:0]    lpidReg,
  input  logic [ID_W-1:0]    pidReg,
  output logic [ID_W-1:0]    lpidSel,
  output logic [ID_W-1:0]    pidSel,
  output logic               addrOk,
  output logic               excValid,
  output logic [2:0]         excCode,
  output logic [CAUSE_W-1:0] errCode,
  output logic [CAUSE_W-1:0] dsisr,
  output logic [EA_W-1:0]    dar,
  output logic [CAUSE_W-1:0] hdsisr,
  output logic [EA_W-1:0]    hdar,
  output logic [EA_W-1:0]    asdr
);
  strobe_t  strobes;
  excCode_e codeEnum;

  fcu_qualify #(.EA_W(EA_W), .ID_W(ID_W)) u_qualify (
    .effAddr (effAddr),
    .hvState (hvState),
    .lpidReg (lpidReg),
    .pidReg  (pidReg),
    .lpidSel (lpidSel),
    .pidSel  (pidSel),
    .addrOk  (addrOk)
  );

  fcu_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .faultValid (faultValid),
    .accessType (accessType),
    .faultClass (faultClass),
    .addrOk     (addrOk),
    .strobes    (strobes),
    .excValid   (excValid),
    .excCode    (codeEnum)
  );

  assign excCode = codeEnum;

  fcu_datapath #(.EA_W(EA_W), .CAUSE_W(CAUSE_W), .STORE_BIT(STORE_BIT)) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .effAddr       (effAddr),
    .guestRealAddr (guestRealAddr),
    .causeIn       (causeIn),
    .errCode       (errCode),
    .dsisr         (dsisr),
    .dar           (dar),
    .hdsisr        (hdsisr),
    .hdar          (hdar),
    .asdr          (asdr)
  );

endmodule

// File: rtl/fcu_checker.sv
module fcu_checker #(
  parameter int EA_W    = 64,
  parameter int CAUSE_W = 32,
  parameter int ID_W    = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               faultValid,
  input logic [EA_W-1:0]    effAddr,
  input logic [EA_W-1:0]    guestRealAddr,
  input logic               hvState,
  input logic [ID_W-1:0]    lpidReg,
  input logic [ID_W-1:0]    lpidSel,
  input logic               addrOk,
  input logic               excValid,
  input logic [2:0]         excCode,
  input logic [CAUSE_W-1:0] errCode,
  input logic [CAUSE_W-1:0] dsisr,
  input logic [EA_W-1:0]    dar,
  input logic [CAUSE_W-1:0] hdsisr,
  input logic [EA_W-1:0]    hdar,
  input logic [EA_W-1:0]    asdr
);
  assert_pulse_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> excValid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rstN)
    !faultValid |=> !excValid);

  assert_code_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (excCode != 3'd0) && (excCode <= 3'd6));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !faultValid |=> $stable(errCode) && $stable(dsisr) && $stable(dar)
                    && $stable(hdsisr) && $stable(hdar) && $stable(asdr));

  assert_isi_keeps_R6: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excCode == 3'd3) |-> $stable(dsisr) && $stable(dar));

  assert_dsi_addr_R7: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excCode == 3'd4) |-> (dar == $past(effAddr)) && (errCode == '0));

  assert_hdsi_addr_R9: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excCode == 3'd6) |-> (hdar == $past(effAddr))
       && (asdr == $past(guestRealAddr)) && (errCode == '0));

  assert_guest_lpid_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!hvState && addrOk) |-> (lpidSel == lpidReg));

  assert_rsv_field_R3: assert property (@(posedge clk) disable iff (!rstN)
    addrOk |-> (effAddr[EA_W-3 -: 10] == '0));

endmodule

bind fault_capture_unit fcu_checker #(.EA_W(EA_W), .CAUSE_W(CAUSE_W), .ID_W(ID_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .faultValid    (faultValid),
  .effAddr       (effAddr),
  .guestRealAddr (guestRealAddr),
  .hvState       (hvState),
  .lpidReg       (lpidReg),
  .lpidSel       (lpidSel),
  .addrOk        (addrOk),
  .excValid      (excValid),
  .excCode       (excCode),
  .errCode       (errCode),
  .dsisr         (dsisr),
  .dar           (dar),
  .hdsisr        (hdsisr),
  .hdar          (hdar),
  .asdr          (asdr)
);

// File: tb/sim_fault_capture_unit.sv
module sim_fault_capture_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        faultValid = 1'b0;
  logic [1:0]  accessType = '0;
  logic [1:0]  faultClass = '0;
  logic [63:0] effAddr = '0;
  logic [63:0] guestRealAddr = '0;
  logic [31:0] causeIn = '0;
  logic        hvState = 1'b0;
  logic [31:0] lpidReg = 32'h0000_0ABC;
  logic [31:0] pidReg = 32'h0001_2345;
  logic [31:0] lpidSel, pidSel;
  logic        addrOk, excValid;
  logic [2:0]  excCode;
  logic [31:0] errCode, dsisr, hdsisr;
  logic [63:0] dar, hdar, asdr;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic [2:0]  code;
    logic [31:0] err, dsisr, hdsisr;
    logic [63:0] dar, hdar, asdr;
  } exp_t;

  exp_t expQ[$];
  exp_t model = '{3'd0, 32'd0, 32'd0, 32'd0, 64'd0, 64'd0, 64'd0};
  exp_t seen  = '{3'd0, 32'd0, 32'd0, 32'd0, 64'd0, 64'd0, 64'd0};

  always #5 clk = ~clk;

  fault_capture_unit u0 (
    .clk(clk), .rstN(rstN), .faultValid(faultValid), .accessType(accessType),
    .faultClass(faultClass), .effAddr(effAddr), .guestRealAddr(guestRealAddr),
    .causeIn(causeIn), .hvState(hvState), .lpidReg(lpidReg), .pidReg(pidReg),
    .lpidSel(lpidSel), .pidSel(pidSel), .addrOk(addrOk), .excValid(excValid),
    .excCode(excCode), .errCode(errCode), .dsisr(dsisr), .dar(dar),
    .hdsisr(hdsisr), .hdar(hdar), .asdr(asdr)
  );

  task automatic check64(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compareAll(input string req, input exp_t e);
    check64(req, "excCode", 64'(excCode), 64'(e.code));
    check64(req, "errCode", 64'(errCode), 64'(e.err));
    check64(req, "dsisr",   64'(dsisr),   64'(e.dsisr));
    check64(req, "dar",     dar,          e.dar);
    check64(req, "hdsisr",  64'(hdsisr),  64'(e.hdsisr));
    check64(req, "hdar",    hdar,         e.hdar);
    check64(req, "asdr",    asdr,         e.asdr);
  endtask

  // Monitor: pops an expectation whenever a pulse appears, else checks the hold (R10)
  always @(negedge clk) begin
    if (rstN) begin
      if (excValid) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected pulse: actual 1 expected 0");
        end else begin
          seen = expQ.pop_front();
          compareAll("R2/R3/R6/R7/R8/R9", seen);
        end
      end else begin
        compareAll("R10", seen);
      end
    end
  end

  // Driver: computes the expectation from the requirements and applies one fault
  task automatic fire(input logic [1:0] acc, input logic [1:0] cls, input logic hv,
                      input logic [63:0] ea, input logic [63:0] gra, input logic [31:0] cause);
    logic [1:0]  quad;
    logic        bad, isF, isS;
    logic [31:0] cs;
    quad = ea[63:62];
    bad  = (ea[61:52] != 10'd0) || (!hv && (quad == 2'd1 || quad == 2'd2));
    isF  = (acc == 2'd0);
    isS  = (acc == 2'd2);
    cs   = isS ? (cause | 32'h0200_0000) : cause;
    if (bad || cls == 2'd0) begin
      model.code = isF ? 3'd1 : 3'd2;
      model.err  = '0;
      if (!isF) model.dar = ea;
    end else if (cls == 2'd1) begin
      if (isF) begin
        model.code = 3'd3; model.err = cause;
      end else begin
        model.code = 3'd4; model.dsisr = cs; model.dar = ea; model.err = '0;
      end
    end else begin
      model.asdr = gra;
      if (isF) begin
        model.code = 3'd5; model.err = cause;
      end else begin
        model.code = 3'd6; model.hdsisr = cs; model.hdar = ea; model.err = '0;
      end
    end
    expQ.push_back(model);
    accessType = acc; faultClass = cls; hvState = hv;
    effAddr = ea; guestRealAddr = gra; causeIn = cause;
    faultValid = 1'b1;
    @(negedge clk);
    faultValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quadCheck(input string req, input logic hv, input logic [63:0] ea,
                           input logic [31:0] expL, input logic [31:0] expP, input logic expOk);
    hvState = hv; effAddr = ea;
    #1;
    check64(req, "lpidSel", 64'(lpidSel), 64'(expL));
    check64(req, "pidSel",  64'(pidSel),  64'(expP));
    check64(req, "addrOk",  64'(addrOk),  64'(expOk));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check64("R1", "excValid", 64'(excValid), 64'd0);
    compareAll("R1", seen);
    rstN = 1'b1;
    @(negedge clk);

    // R4: hypervisor quadrant table
    quadCheck("R4", 1'b1, 64'h0000_0000_0000_1000, 32'd0,   pidReg, 1'b1);
    quadCheck("R4", 1'b1, 64'h4000_0000_0000_1000, lpidReg, pidReg, 1'b1);
    quadCheck("R4", 1'b1, 64'h8000_0000_0000_1000, lpidReg, 32'd0,  1'b1);
    quadCheck("R4", 1'b1, 64'hC000_0000_0000_1000, 32'd0,   32'd0,  1'b1);
    // R5: guest quadrant table
    quadCheck("R5", 1'b0, 64'h0000_0000_0000_2000, lpidReg, pidReg, 1'b1);
    quadCheck("R5", 1'b0, 64'h4000_0000_0000_2000, 32'd0,   32'd0,  1'b0);
    quadCheck("R5", 1'b0, 64'h8000_0000_0000_2000, 32'd0,   32'd0,  1'b0);
    quadCheck("R5", 1'b0, 64'hC000_0000_0000_2000, lpidReg, 32'd0,  1'b1);
    // R3: reserved field
    quadCheck("R3", 1'b1, 64'h0010_0000_0000_0000, 32'd0,   pidReg, 1'b0);
    quadCheck("R3", 1'b0, 64'h2000_0000_0000_0000, lpidReg, pidReg, 1'b0);
    @(negedge clk);

    fire(2'd0, 2'd1, 1'b0, 64'h0000_0000_0000_4000, 64'd0, 32'h4000_0000); // R6
    idle(2);
    fire(2'd1, 2'd1, 1'b0, 64'h0000_0000_0000_5008, 64'd0, 32'h4000_0000); // R7 load
    fire(2'd2, 2'd1, 1'b1, 64'hC000_0000_0001_0010, 64'd0, 32'h0800_0000); // R7 store, back to back
    idle(2);
    fire(2'd0, 2'd2, 1'b0, 64'h0000_0000_0003_0000, 64'h0000_0000_7770_0000, 32'h0000_1000); // R8
    idle(1);
    fire(2'd2, 2'd2, 1'b0, 64'hC000_0000_0004_0000, 64'h0000_0000_8880_0000, 32'h4000_0000); // R9 store
    fire(2'd1, 3'd3, 1'b1, 64'h4000_0000_0005_0000, 64'h0000_0000_9990_0000, 32'h0000_0020); // R9 load, class 3
    idle(2);
    fire(2'd1, 2'd0, 1'b1, 64'h0000_0000_0006_0000, 64'd0, 32'hFFFF_FFFF); // R3 data segment
    fire(2'd0, 2'd0, 1'b1, 64'h0000_0000_0007_0000, 64'd0, 32'h1234_5678); // R3 instruction segment
    idle(1);
    fire(2'd2, 2'd1, 1'b1, 64'h0020_0000_0000_8000, 64'd0, 32'h4000_0000); // R3 bad field overrides storage
    fire(2'd2, 2'd2, 1'b0, 64'h4000_0000_0000_9000, 64'h55, 32'h4000_0000); // R5 illegal guest quadrant
    fire(2'd0, 2'd1, 1'b0, 64'h8000_0000_0000_A000, 64'd0, 32'h1); // R5 illegal quadrant on fetch
    idle(3); // R10 hold
    fire(2'd3, 2'd1, 1'b1, 64'h0000_0000_0000_B000, 64'd0, 32'h0000_0400); // R7 alt access as load
    idle(2);

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2 missing pulses: actual %0d pending expected 0", expQ.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule